// File: doc/BRIEF.md
# Per-Channel Measurement Averaging Engine

This block averages a stream of raw samples for six monitored channels. Each sample arrives with a channel index. The block keeps a running sum and a sample count for every channel. When a channel has collected its configured number of samples, the block divides the sum by that number and writes the result to the channel's reading register. A reading register changes only at that point and otherwise holds its last value.

The number of samples per reading comes from a 3-bit averaging field in an 8-bit configuration register. The field is priority decoded, so its top bit wins. The count also depends on the channel class. Channels 0 and 1 are remote-diode channels. Channels 2 to 5 carry voltage and internal sensor readings.

The same configuration register holds a low-power select bit, a monitoring-mode bit and a global interrupt-enable bit. A lock input freezes the register against writes. The lock is sticky and clears only on reset.

Top module: `avg_engine`

## Requirements
- R1: After reset the configuration register reads 0x40, every reading register is 0, and `int_en_o` is 0.
- R2: A write while unlocked loads `cfg_wdata_i` into the configuration register. The new value appears on `cfg_o` at the next clock edge.
- R3: A write is ignored in the cycle where `lock_i` is high and in every cycle after that until reset. `cfg_o` stays readable throughout.
- R4: `int_en_o` equals configuration bit 2.
- R5: When averaging field bit 7 is 1, every channel uses 32 samples per reading, whatever bits 6:5 hold.
- R6: When bits 7:6 are 01, every channel uses 16 samples per reading.
- R7: When bits 7:5 are 000, channels 0 and 1 use 128 samples and channels 2 to 5 use 8.
- R8: When bits 7:5 are 001, channels 0 and 1 use 16 samples and channels 2 to 5 use 1.
- R9: When a channel's window completes, its reading becomes floor(sum of the window's samples / count), one cycle after the last sample. Between completions the reading holds.
- R10: The sample count for a window is fixed by the field value in the cycle of the window's first sample. A field change during a window takes effect only from the next window.
- R11: A sample changes only the state of the channel it is addressed to.
- R12: A sample with a channel index of 6 or 7 has no effect on any reading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| lock_i | input | 1 | Lock request (sticky) |
| smp_valid_i | input | 1 | Sample valid |
| smp_ch_i | input | 3 | Sample channel index |
| smp_data_i | input | 8 | Sample value |
| cfg_o | output | 8 | Configuration register value |
| int_en_o | output | 1 | Global interrupt enable |
| rd_o | output | 48 | Reading registers; channel n sits at bits [8n+7:8n] |

## Verification
The assertions check on every cycle that:
- the register is frozen once a lock has been seen;
- an unlocked write lands on the next edge;
- the interrupt enable tracks bit 2;
- the readings stay frozen when no sample arrives or the index is out of range.

Only the bench's scenarios can show the averaging itself:
- the per-class sample counts under each field pattern;
- the floor-mean values;
- a field change arriving mid-window;
- the independence of the channels.

The bench checks these against a reference model running mixed random traffic and directed windows.

// File: rtl/avg_pkg.sv
package avg_pkg;
  localparam int CFG_W = 8;
  localparam logic [CFG_W-1:0] CFG_RST = 8'h40;
  localparam int CFG_IE_BIT = 2;
  localparam int AVG_LSB = 5;
  localparam int MAX_SH = 7;            // 128 samples
  localparam int SH_W = $clog2(MAX_SH + 1);
  typedef logic [SH_W-1:0] shift_t;
endpackage

// File: rtl/avg_cfg_reg.sv
module avg_cfg_reg
  import avg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             lock_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      cfg_o    <= CFG_RST;
    end else begin
      locked_q <= locked_q | lock_i;
      if (we_i && !lock_i && !locked_q) cfg_o <= wdata_i;
    end
  end
endmodule

// File: rtl/avg_shift_decode.sv
module avg_shift_decode
  import avg_pkg::*;
#(
  parameter bit IS_REMOTE = 1'b0
) (
  input  logic [2:0] avg_i,
  output shift_t     sh_o
);
  // priority: bit 2 over bit 1 over bit 0
  always_comb begin
    if (avg_i[2])      sh_o = shift_t'(5);
    else if (avg_i[1]) sh_o = shift_t'(4);
    else if (avg_i[0]) sh_o = IS_REMOTE ? shift_t'(4) : shift_t'(0);
    else               sh_o = IS_REMOTE ? shift_t'(7) : shift_t'(3);
  end
endmodule

// File: rtl/avg_channel.sv
module avg_channel
  import avg_pkg::*;
#(
  parameter int SMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_en_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  shift_t           new_sh_i,
  output logic [SMP_W-1:0] rd_o
);
  localparam int ACC_W = SMP_W + MAX_SH;
  localparam int CNT_W = MAX_SH + 1;

  logic [ACC_W-1:0] acc_q, acc_n;
  logic [CNT_W-1:0] cnt_q, tgt;
  shift_t           sh_q, sh_use;
  logic             done;

  // window count latched at its first sample
  assign sh_use = (cnt_q == '0) ? new_sh_i : sh_q;
  assign tgt    = CNT_W'(1) << sh_use;
  assign acc_n  = acc_q + ACC_W'(smp_data_i);
  assign done   = (cnt_q + CNT_W'(1)) == tgt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      sh_q  <= '0;
      rd_o  <= '0;
    end else if (smp_en_i) begin
      sh_q <= sh_use;
      if (done) begin
        rd_o  <= SMP_W'(acc_n >> sh_use);
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= acc_n;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/avg_engine.sv
module avg_engine
  import avg_pkg::*;
#(
  parameter int                NUM_CH      = 6,
  parameter int                SMP_W       = 8,
  parameter logic [NUM_CH-1:0] REMOTE_MASK = 6'b000011,
  localparam int               CH_W        = $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [CFG_W-1:0]        cfg_wdata_i,
  input  logic                    lock_i,
  input  logic                    smp_valid_i,
  input  logic [CH_W-1:0]         smp_ch_i,
  input  logic [SMP_W-1:0]        smp_data_i,
  output logic [CFG_W-1:0]        cfg_o,
  output logic                    int_en_o,
  output logic [NUM_CH*SMP_W-1:0] rd_o
);
  logic [2:0] avg_fld;

  avg_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .lock_i  (lock_i),
    .cfg_o   (cfg_o)
  );

  assign int_en_o = cfg_o[CFG_IE_BIT];
  assign avg_fld  = cfg_o[AVG_LSB +: 3];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    shift_t sh;
    logic   en;

    assign en = smp_valid_i && (smp_ch_i == CH_W'(g));

    avg_shift_decode #(.IS_REMOTE(REMOTE_MASK[g])) u_dec (
      .avg_i (avg_fld),
      .sh_o  (sh)
    );

    avg_channel #(.SMP_W(SMP_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .smp_en_i   (en),
      .smp_data_i (smp_data_i),
      .new_sh_i   (sh),
      .rd_o       (rd_o[g*SMP_W +: SMP_W])
    );
  end
endmodule

// File: rtl/avg_engine_chk.sv
module avg_engine_chk #(
  parameter int NUM_CH = 6,
  parameter int SMP_W  = 8,
  parameter int CH_W   = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cfg_we_i,
  input logic [7:0]              cfg_wdata_i,
  input logic                    lock_i,
  input logic                    smp_valid_i,
  input logic [CH_W-1:0]         smp_ch_i,
  input logic [7:0]              cfg_o,
  input logic                    int_en_o,
  input logic [NUM_CH*SMP_W-1:0] rd_o
);
  logic seen_lock_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_lock_q <= 1'b0;
    else         seen_lock_q <= seen_lock_q | lock_i;
  end

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !lock_i && !seen_lock_q) |=> (cfg_o == $past(cfg_wdata_i)));

  p_locked_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i || seen_lock_q) |=> $stable(cfg_o));

  p_inten_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_en_o == cfg_o[2]);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(rd_o));

  p_bad_ch_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && (int'(smp_ch_i) >= NUM_CH)) |=> $stable(rd_o));
endmodule

bind avg_engine avg_engine_chk #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .CH_W(CH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .lock_i      (lock_i),
  .smp_valid_i (smp_valid_i),
  .smp_ch_i    (smp_ch_i),
  .cfg_o       (cfg_o),
  .int_en_o    (int_en_o),
  .rd_o        (rd_o)
);

// File: tb/tb_avg_engine.sv
module tb_avg_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        lock_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [2:0]  smp_ch_i = '0;
  logic [7:0]  smp_data_i = '0;
  logic [7:0]  cfg_o;
  logic        int_en_o;
  logic [47:0] rd_o;

  int total = 0;
  int bad = 0;

  // reference model
  logic [7:0] m_cfg = 8'h40;
  bit         m_lock = 0;
  int         m_acc[6];
  int         m_cnt[6];
  int         m_sh[6];
  logic [7:0] m_rd[6];

  always #4 clk_i = ~clk_i;

  avg_engine dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .lock_i(lock_i), .smp_valid_i(smp_valid_i), .smp_ch_i(smp_ch_i),
    .smp_data_i(smp_data_i), .cfg_o(cfg_o), .int_en_o(int_en_o), .rd_o(rd_o)
  );

  // samples per reading as log2, from the requirement table
  function automatic int want_log2(logic [7:0] cfg, int ch);
    bit remote = (ch < 2);
    casez (cfg[7:5])
      3'b1??:  return 5;
      3'b01?:  return 4;
      3'b001:  return remote ? 4 : 0;
      default: return remote ? 7 : 3;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rd(string req);
    for (int c = 0; c < 6; c++) chk(req, rd_o[c*8 +: 8], m_rd[c]);
  endtask

  task automatic wr_cfg(logic [7:0] v, bit lk = 0);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_wdata_i = v; lock_i = lk;
    @(negedge clk_i);
    cfg_we_i = 0; lock_i = 0;
    if (lk) m_lock = 1;
    if (!m_lock) m_cfg = v;
  endtask

  task automatic smp(int ch, int d);
    @(negedge clk_i);
    smp_valid_i = 1; smp_ch_i = 3'(ch); smp_data_i = 8'(d);
    if (ch < 6) begin
      int sh = (m_cnt[ch] == 0) ? want_log2(m_cfg, ch) : m_sh[ch];
      m_acc[ch] += d;
      m_cnt[ch]++;
      m_sh[ch] = sh;
      if (m_cnt[ch] == (1 << sh)) begin
        m_rd[ch]  = 8'(m_acc[ch] >> sh);
        m_acc[ch] = 0;
        m_cnt[ch] = 0;
      end
    end
    @(negedge clk_i);
    smp_valid_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int c = 0; c < 6; c++) begin
      m_acc[c] = 0; m_cnt[c] = 0; m_sh[c] = 0; m_rd[c] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 cfg", cfg_o, 8'h40);
    chk("R1 inten", int_en_o, 0);
    chk("R1 rd", rd_o, 0);

    // R6 default field 010: 16 samples on all channels
    for (int i = 0; i < 15; i++) smp(0, 10);
    chk("R6 rd0 held", rd_o[7:0], 0);
    smp(0, 10);
    chk("R6 rd0", rd_o[7:0], 10);

    // R2, R4
    wr_cfg(8'h44);
    chk("R2 cfg", cfg_o, 8'h44);
    chk("R4 inten on", int_en_o, 1);
    wr_cfg(8'h40);
    chk("R4 inten off", int_en_o, 0);

    // R5 field 111 still 32 samples
    wr_cfg(8'hE0);
    for (int i = 0; i < 31; i++) smp(2, i);
    chk("R5 rd2 held", rd_o[23:16], 0);
    smp(2, 31);
    chk("R5 rd2", rd_o[23:16], 15);

    // R7 field 000: 128 remote, 8 other
    wr_cfg(8'h00);
    for (int i = 0; i < 7; i++) smp(3, 20 + i);
    chk("R7 rd3 held", rd_o[31:24], 0);
    smp(3, 100);
    chk("R7 rd3", rd_o[31:24], (20+21+22+23+24+25+26+100) >> 3);
    for (int i = 0; i < 127; i++) smp(1, 200);
    chk("R7 rd1 held", rd_o[15:8], 0);
    smp(1, 72);
    chk("R7 rd1", rd_o[15:8], (127*200 + 72) >> 7);

    // R8 field 001: 1 on others, 16 on remote
    wr_cfg(8'h20);
    smp(4, 77);
    chk("R8 rd4 immediate", rd_o[39:32], 77);
    for (int i = 0; i < 15; i++) smp(0, 3);
    chk("R8 rd0 held", rd_o[7:0], 10);
    smp(0, 3);
    chk("R8 rd0", rd_o[7:0], 3);

    // R10 mid-window change keeps old count
    wr_cfg(8'h00);
    for (int i = 0; i < 3; i++) smp(5, 40);
    wr_cfg(8'h20);
    for (int i = 0; i < 4; i++) smp(5, 40);
    chk("R10 rd5 held", rd_o[47:40], 0);
    smp(5, 48);
    chk("R10 rd5 old count", rd_o[47:40], 41);
    smp(5, 9);
    chk("R10 rd5 new count", rd_o[47:40], 9);

    // R12 out-of-range indexes
    smp(6, 255);
    smp(7, 255);
    chk_rd("R12");

    // R11, R9 random traffic with the model
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 40) == 0) wr_cfg(8'($urandom()));
      smp($urandom_range(0, 5), $urandom_range(0, 255));
      chk_rd("R9/R11");
    end
    chk("R4 random cfg", int_en_o, m_cfg[2]);

    // R3 lock
    wr_cfg(8'h55, 1);
    chk("R3 locked write", cfg_o, m_cfg);
    wr_cfg(8'hAA);
    chk("R3 sticky", cfg_o, m_cfg);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule